// File: doc/BRIEF.md
# Vectored Fixed-Priority Interrupt Controller

This block sits next to a small 8-bit processor core and decides when the core should leave its program to service a peripheral. Each peripheral delivers a raw event pulse. The block latches every event into a per-source pending flag. It gates the flags with a per-source enable mask and with one global enable. It evaluates the gated flags only when the core signals that an instruction has completed.

When a gated flag is found at such a boundary, the block raises a one-cycle take request. The core uses that request to push its return address, and the block supplies the byte address of the vector at the same time. In the same step the block clears the chosen flag and drops the global enable. A return strobe from the core sets the global enable again. After a return, the block holds off vectoring until one instruction of the resumed program has completed.

Priority comes only from the position of a source in the vector table. The spacing between vector entries is fixed at build time to 2 or 4 bytes, to match short-jump or long-jump table entries.

Top module: `intc_top`

## Requirements
- R1: An event pulse on source i sets pending bit i, and `pend_o[i]` shows it in the cycle after the event. The bit is set regardless of the source enable and the global enable.
- R2: A source can cause vectoring only when its pending bit, its enable bit and the global enable are all set. The enables are loaded by `en_wr_i` and `gie_wr_i` and take effect in the following cycle.
- R3: Vectoring is decided only in a cycle with `bnd_i` high. When several sources qualify, the lowest index is chosen, and all other pending bits are left set.
- R4: A decision in cycle t raises `take_o` for exactly cycle t+1. In that cycle `vec_addr_o` holds (i+1)*2 for source i when LONG_VEC=0, or (i+1)*4 when LONG_VEC=1. Vector 0, at address 0, is reserved for reset, so source 0 maps to vector 1.
- R5: When a vector is taken, the chosen pending bit and the global enable (`gie_o`) are both clear in cycle t+1.
- R6: A bit that became pending while the global enable was clear causes vectoring at the first boundary after the global enable is set.
- R7: Several events on one source before it is serviced cause exactly one vectoring.
- R8: `reti_i` sets the global enable. No vectoring happens in the cycle of `reti_i`, nor at the first later boundary. Vectoring is allowed again from the boundary after that.
- R9: An event that arrives in the same cycle as the automatic clear of its bit, or in the same cycle as a software clear of its bit, leaves the bit set.
- R10: Writing 1 to bit i of `clr_i` clears pending bit i in the next cycle. Writing 0 to a bit leaves that bit unchanged.
- R11: A synchronous reset clears all pending bits, all source enables, the global enable, the hold-off state and `take_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_SRC | Raw event pulses, one per source |
| en_wr_i | input | 1 | Load the source enable mask |
| en_data_i | input | NUM_SRC | New source enable mask |
| gie_wr_i | input | 1 | Load the global enable |
| gie_data_i | input | 1 | New global enable value |
| clr_i | input | NUM_SRC | Write-1-to-clear mask for the pending bits |
| bnd_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | Take interrupt: push the return PC and jump |
| vec_addr_o | output | ADDR_W | Vector byte address, valid while take_o is high |
| gie_o | output | 1 | Current global enable |
| pend_o | output | NUM_SRC | Current pending bits |

## Verification
The assertions check the following on every cycle:
- an event is never lost against a clear;
- a software clear takes effect;
- a take follows only a boundary at which the global enable was set and no hold-off was active;
- a take leaves the global enable clear and lasts a single cycle.

The lowest-index choice, the vector address scaling for both spacings, the merging of repeated events, the deferred firing once the global enable returns, and the exact boundary at which vectoring resumes after a return depend on multi-cycle histories. Those are shown by the bench's scenarios, which compare against a behavioural model on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Byte address of the vector serving source idx; vector 0 is reset.
  function automatic int unsigned vec_byte_addr(input int unsigned idx, input bit long_form);
    return (idx + 1) << (long_form ? 2 : 1);
  endfunction
endpackage

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] sw_clr_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] flag_q;

  // Set beats clear so that a coinciding event is never dropped.
  always_ff @(posedge clk_i) begin
    if (rst_i) flag_q <= '0;
    else       flag_q <= (flag_q & ~(sw_clr_i | ack_i)) | evt_i;
  end

  assign pend_o = flag_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    a_r9_event_kept: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(evt_i[g]) && !$past(rst_i)) |-> pend_o[g])
      else $error("event lost on source %0d", g);
    a_r10_sw_clear: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(sw_clr_i[g]) && !$past(evt_i[g]) && !$past(rst_i)) |-> !pend_o[g])
      else $error("software clear ignored on source %0d", g);
    a_r1_hold: assert property (@(posedge clk_i) disable iff (rst_i)
      ($past(pend_o[g]) && !$past(sw_clr_i[g]) && !$past(ack_i[g]) && !$past(rst_i)) |-> pend_o[g])
      else $error("pending bit %0d dropped without a clear", g);
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [NUM_SRC-1:0] grant_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  // Prefix chain: blocked[i] is high when some lower index requests.
  logic [NUM_SRC:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant_o[i]   = req_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req_i[i];
  end

  assign any_o = blocked[NUM_SRC];

  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/intc_seq.sv
module intc_seq #(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 8,
  parameter bit LONG_VEC = 1'b0,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_data_i,
  input  logic               gie_wr_i,
  input  logic               gie_data_i,
  input  logic               bnd_i,
  input  logic               reti_i,
  input  logic [NUM_SRC-1:0] grant_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               any_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] ack_o,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               gie_o
);
  import intc_pkg::*;

  logic [NUM_SRC-1:0] en_q;
  logic               gie_q;
  logic               hold_q;
  logic               take_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               fire;

  assign fire  = bnd_i & gie_q & any_i & ~hold_q & ~reti_i;
  assign ack_o = fire ? grant_i : '0;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
      take_q <= 1'b0;
      addr_q <= '0;
    end else begin
      if (en_wr_i) en_q <= en_data_i;
      if (fire)          gie_q <= 1'b0;
      else if (reti_i)   gie_q <= 1'b1;
      else if (gie_wr_i) gie_q <= gie_data_i;
      // A return arms the hold-off; the next strictly later boundary releases it.
      if (reti_i)     hold_q <= 1'b1;
      else if (bnd_i) hold_q <= 1'b0;
      take_q <= fire;
      if (fire) addr_q <= ADDR_W'(vec_byte_addr(32'(idx_i), LONG_VEC));
    end
  end

  assign en_o       = en_q;
  assign take_o     = take_q;
  assign vec_addr_o = addr_q;
  assign gie_o      = gie_q;

  a_r4_take_at_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> $past(bnd_i))
    else $error("take without a boundary");
  a_r2_take_needs_gie: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> $past(gie_o))
    else $error("take while global enable was clear");
  a_r5_gie_dropped: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> !gie_o)
    else $error("global enable still set after take");
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |=> !take_o)
    else $error("take lasted more than one cycle");
  a_r8_holdoff: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |-> (!$past(hold_q) && !$past(reti_i)))
    else $error("vectored inside the post-return hold-off");
endmodule

// File: rtl/intc_top.sv
module intc_top #(
  parameter int NUM_SRC  = 8,
  parameter int ADDR_W   = 8,
  parameter bit LONG_VEC = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               en_wr_i,
  input  logic [NUM_SRC-1:0] en_data_i,
  input  logic               gie_wr_i,
  input  logic               gie_data_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               bnd_i,
  input  logic               reti_i,
  output logic               take_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] pend_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC-1:0] ack;
  logic [IDX_W-1:0]   idx;
  logic               any;

  assign req = pend & en;

  intc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(evt_i),
    .sw_clr_i(clr_i), .ack_i(ack), .pend_o(pend)
  );

  intc_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .req_i(req), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  intc_seq #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .LONG_VEC(LONG_VEC)) u_seq (
    .clk_i(clk_i), .rst_i(rst_i),
    .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .gie_wr_i(gie_wr_i), .gie_data_i(gie_data_i),
    .bnd_i(bnd_i), .reti_i(reti_i),
    .grant_i(grant), .idx_i(idx), .any_i(any),
    .en_o(en), .ack_o(ack),
    .take_o(take_o), .vec_addr_o(vec_addr_o), .gie_o(gie_o)
  );

  assign pend_o = pend;

  a_r3_one_ack: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(ack))
    else $error("more than one source acknowledged");
endmodule

// File: tb/intc_top_tb_top.sv
module intc_top_tb_top;
  localparam int N  = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] evt = '0, en_data = '0, clr = '0;
  logic en_wr = 1'b0, gie_wr = 1'b0, gie_data = 1'b0, bnd = 1'b0, reti = 1'b0;
  logic take_s, take_l, gie_s, gie_l;
  logic [AW-1:0] va_s, va_l;
  logic [N-1:0] pend_s, pend_l;

  always #4 clk = ~clk;

  intc_top #(.NUM_SRC(N), .ADDR_W(AW), .LONG_VEC(1'b0)) dut_i (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .en_wr_i(en_wr), .en_data_i(en_data),
    .gie_wr_i(gie_wr), .gie_data_i(gie_data), .clr_i(clr), .bnd_i(bnd), .reti_i(reti),
    .take_o(take_s), .vec_addr_o(va_s), .gie_o(gie_s), .pend_o(pend_s));

  intc_top #(.NUM_SRC(N), .ADDR_W(AW), .LONG_VEC(1'b1)) dut_l (
    .clk_i(clk), .rst_i(rst), .evt_i(evt), .en_wr_i(en_wr), .en_data_i(en_data),
    .gie_wr_i(gie_wr), .gie_data_i(gie_data), .clr_i(clr), .bnd_i(bnd), .reti_i(reti),
    .take_o(take_l), .vec_addr_o(va_l), .gie_o(gie_l), .pend_o(pend_l));

  int checks = 0, fails = 0, ntake = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  bit m_p[N];
  bit m_en[N];
  bit m_g, m_hold, m_take;
  int m_addr;

  always @(posedge clk) begin
    int win;
    bit fire;
    if (rst) begin
      foreach (m_p[i]) begin m_p[i] = 0; m_en[i] = 0; end
      m_g = 0; m_hold = 0; m_take = 0; m_addr = 0;
    end else begin
      win = -1;
      for (int i = N - 1; i >= 0; i--) if (m_p[i] && m_en[i]) win = i;
      fire = bnd && m_g && (win >= 0) && !m_hold && !reti;
      for (int i = 0; i < N; i++) begin
        if (evt[i]) m_p[i] = 1;
        else if (clr[i] || (fire && win == i)) m_p[i] = 0;
      end
      if (en_wr) foreach (m_en[i]) m_en[i] = en_data[i];
      if (fire) m_g = 0; else if (reti) m_g = 1; else if (gie_wr) m_g = gie_data;
      if (reti) m_hold = 1; else if (bnd) m_hold = 0;
      m_take = fire;
      if (fire) m_addr = (win + 1) * 2;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    int mp;
    mp = 0;
    for (int i = 0; i < N; i++) if (m_p[i]) mp |= (1 << i);
    chk(pend_s == N'(mp) && pend_l == N'(mp), "R1 pending model", int'(pend_s), mp);
    chk(take_s == m_take && take_l == m_take, "R4 take model", int'(take_s), int'(m_take));
    chk(gie_s == m_g && gie_l == m_g, "R5 gie model", int'(gie_s), int'(m_g));
    if (m_take) begin
      chk(int'(va_s) == m_addr, "R4 short vector", int'(va_s), m_addr);
      chk(int'(va_l) == 2 * m_addr, "R4 long vector", int'(va_l), 2 * m_addr);
    end
    if (take_s) ntake++;
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input logic [N-1:0] e, input logic [N-1:0] c,
                      input logic b, input logic r);
    evt = e; clr = c; bnd = b; reti = r;
    @(negedge clk);
    evt = '0; clr = '0; bnd = 0; reti = 0;
  endtask
  task automatic set_en(input logic [N-1:0] m);
    en_wr = 1; en_data = m; @(negedge clk); en_wr = 0;
  endtask
  task automatic set_gie(input logic v);
    gie_wr = 1; gie_data = v; @(negedge clk); gie_wr = 0;
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk(pend_s == '0 && !take_s && !gie_s, "R11 reset state", int'(pend_s), 0);

    // R1: events latch with everything disabled; R2: no take
    step(8'h28, '0, 0, 0);
    chk(pend_s == 8'h28, "R1 latch while disabled", int'(pend_s), 8'h28);
    step('0, '0, 1, 0);
    chk(!take_s, "R2 no take without enables", int'(take_s), 0);
    set_en(8'h08);
    step('0, '0, 1, 0);
    chk(!take_s, "R2 no take without global enable", int'(take_s), 0);

    // R6: deferred flag fires at first boundary after gie set
    set_gie(1);
    step('0, '0, 1, 0);
    chk(take_s && va_s == 8'd8 && va_l == 8'd16, "R6 deferred take vector", int'(va_s), 8);
    chk(pend_s == 8'h20 && !gie_s, "R5 flag and gie cleared", int'(pend_s), 8'h20);
    @(negedge clk);
    chk(!take_s, "R4 take single cycle", int'(take_s), 0);

    // R8: return hold-off
    set_en(8'hFF);
    step('0, '0, 0, 1);
    chk(gie_s, "R8 return sets gie", int'(gie_s), 1);
    step('0, '0, 1, 0);
    chk(!take_s, "R8 first boundary after return blocked", int'(take_s), 0);
    step('0, '0, 1, 0);
    chk(take_s && va_s == 8'd12, "R8 second boundary vectors", int'(va_s), 12);

    // R3: lowest index wins, only at a boundary
    step(8'hC4, '0, 0, 0);
    set_gie(1);
    repeat (3) step('0, '0, 0, 0);
    chk(!take_s, "R3 no take between boundaries", int'(take_s), 0);
    step('0, '0, 1, 0);
    chk(take_s && va_s == 8'd6, "R3 lowest index chosen", int'(va_s), 6);
    chk(pend_s == 8'hC0, "R3 others stay pending", int'(pend_s), 8'hC0);

    // R10: software clear
    step('0, 8'h40, 0, 0);
    chk(pend_s == 8'h80, "R10 write-one clears only its bit", int'(pend_s), 8'h80);
    step('0, 8'h80, 0, 0);
    chk(pend_s == 8'h00, "R10 clear all", int'(pend_s), 0);

    // R7: merged events give one vectoring
    repeat (3) step(8'h02, '0, 0, 0);
    t0 = ntake;
    step('0, '0, 0, 1);
    repeat (4) step('0, '0, 1, 0);
    chk(ntake - t0 == 1, "R7 merged events one take", ntake - t0, 1);
    chk(pend_s == 8'h00, "R7 nothing left pending", int'(pend_s), 0);

    // R9: event coinciding with auto clear and with software clear
    step(8'h01, '0, 0, 0);
    step('0, '0, 0, 1);
    step('0, '0, 1, 0);
    step(8'h01, '0, 1, 0);
    chk(take_s && va_s == 8'd2, "R9 take source 0", int'(va_s), 2);
    chk(pend_s[0], "R9 event kept over auto clear", int'(pend_s), 1);
    step(8'h01, 8'h01, 0, 0);
    chk(pend_s[0], "R9 event kept over software clear", int'(pend_s), 1);

    // R11: reset mid-run clears enables too
    rst = 1; @(negedge clk); rst = 0;
    chk(pend_s == '0 && !gie_s && !take_s, "R11 mid-run reset", int'(pend_s), 0);
    step(8'h01, '0, 0, 0);
    set_gie(1);
    step('0, '0, 1, 0);
    chk(!take_s, "R11 enables cleared by reset", int'(take_s), 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule